// File: doc/BRIEF.md
# Access Violation Status Capture

This block sits behind a memory protection checker and records what went wrong when the CPU bus master makes a forbidden access. The checker hands it one pulse per violating cycle, along with a classification and two more facts: whether the CPU was in supervisor state, and the faulting address. The classification is a write to read-only memory, a code fetch from no-execute memory, or neither, which means the address is not covered by any descriptor.

The first violation raises a sticky error flag. In the same edge the block freezes that violation's cause, privilege state and address, and keeps them until software clears the flag. Later violations still raise the interrupt request, because enforcement never depends on the flag, but they leave the recorded data untouched. Software reads the record through four byte registers and clears the flag with a write-one-to-clear. While the flag is set, the block also tells the bus fabric to let the CPU in supervisor state reach the peripheral register space, so that software can always clear the flag.

Top module: `violation_status_capture`

## Requirements
- R1: After reset, every readable byte is 0x00, and `errIrq` and `regAccessOverride` are low.
- R2: A cycle with `violValid` high while the flag is clear does the following at the next clock edge:
  - Status bit 7 (error flag) is set.
  - Bit 6 is loaded from `violWrProt` (write to read-only).
  - Bit 5 is loaded from `violNoExec` (fetch from no-execute). When bits 6 and 5 are both 0, the violation hit uncovered memory.
  - Bit 0 is loaded from `violSuper` (1 = supervisor, 0 = user).
  - All of these can be read at offset 0 one cycle after the violation.
- R3: The captured 23-bit address can be read at three offsets:
  - Offset 1 returns bits 22..16 in bits 6..0, with bit 7 reading 0.
  - Offset 2 returns bits 15..8.
  - Offset 3 returns bits 7..0.
- R4: Bits 4..1 of the status byte always read 0.
- R5: Writing offset 0 with bit 7 = 1 clears the error flag at the next edge. Writing it with bit 7 = 0 leaves the flag unchanged. A clear never alters bits 6, 5, 0 or the captured address.
- R6: While the flag is set, further violations change neither the status bits nor the captured address.
- R7: `errIrq` is high exactly in the cycle after each cycle with `violValid` high, whether or not the flag was already set.
- R8: `regAccessOverride` is high exactly while the error flag is set and `cpuSupervisor` is high.
- R9: If a violation and a clearing write fall in the same cycle, the violation wins. The flag stays set and the new violation's cause, state and address are captured.
- R10: Writes to offsets 1 to 3 are ignored: the read-back is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| violValid | input | 1 | CPU access violation in this cycle |
| violWrProt | input | 1 | Cause: write to read-only memory |
| violNoExec | input | 1 | Cause: fetch from no-execute memory |
| violSuper | input | 1 | CPU was in supervisor state at the violation |
| violAddr | input | 23 | Faulting address |
| cpuSupervisor | input | 1 | CPU currently in supervisor state |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset (0 status, 1..3 address bytes) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` (combinational) |
| errIrq | output | 1 | Violation interrupt request, one cycle per violation |
| regAccessOverride | output | 1 | Grants supervisor access to peripheral registers |

## Verification
The assertions take for granted that the checker never reports both causes at once. A violation is either a write-protect hit, a no-execute hit, or neither, so `violWrProt` and `violNoExec` are not high together. The random stimulus draws the cause as one of three values, so it never produces that pair. The assertions also assume the register interface drives `regAddr` only within 0..3; the two-bit offset holds that by width. Directed cases place a violation together with a clearing write in the same cycle, and send violations while the flag is already set, because random draws reach those two cases only rarely.

// File: rtl/avsc_pkg.sv
package avsc_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic capture;   // load cause, state and address this edge
    logic clear;     // software clear accepted this edge
  } ctrlStrobes_t;

  // Status byte bit positions (software decodes these)
  localparam int AEF_BIT = 7;
  localparam int WPF_BIT = 6;
  localparam int NXF_BIT = 5;
  localparam int SVF_BIT = 0;

endpackage

// File: rtl/avsc_ctrl.sv
module avsc_ctrl
  import avsc_pkg::*;
#(
  parameter int REG_AW = 2,
  parameter int DATA_W = 8,
  parameter int STATUS_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              violValid,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output ctrlStrobes_t      strobes,
  output logic              errFlag,
  output logic              errIrq
);

  localparam logic [REG_AW-1:0] STS_ADDR = REG_AW'(STATUS_OFFSET);

  logic clearHit;
  logic flagNext;
  wire  unusedWrBits = ^regWrData;

  assign clearHit = regWrEn && (regAddr == STS_ADDR) && regWrData[AEF_BIT];

  // A violation captures when nothing is pending, or when the pending
  // record is being cleared in the same cycle (violation has priority).
  always_comb begin
    strobes.capture = violValid && (!errFlag || clearHit);
    strobes.clear   = clearHit && !violValid;
    flagNext        = errFlag;
    if (violValid)    flagNext = 1'b1;
    else if (clearHit) flagNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      errIrq  <= 1'b0;
    end else begin
      errFlag <= flagNext;
      errIrq  <= violValid;
    end
  end

endmodule

// File: rtl/avsc_datapath.sv
module avsc_datapath
  import avsc_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int REG_AW = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              errFlag,
  input  logic              violWrProt,
  input  logic              violNoExec,
  input  logic              violSuper,
  input  logic [ADDR_W-1:0] violAddr,
  input  logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] regRdData
);

  localparam int ADDR_BYTES = (ADDR_W + DATA_W - 1) / DATA_W;
  localparam int PAD_W      = ADDR_BYTES * DATA_W;

  logic              wpfQ, nxfQ, svfQ;
  logic [ADDR_W-1:0] capAddr;
  logic [PAD_W-1:0]  padAddr;
  logic [DATA_W-1:0] addrByte [ADDR_BYTES];
  logic [DATA_W-1:0] statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpfQ    <= 1'b0;
      nxfQ    <= 1'b0;
      svfQ    <= 1'b0;
      capAddr <= '0;
    end else if (strobes.capture) begin
      wpfQ    <= violWrProt;
      nxfQ    <= violNoExec;
      svfQ    <= violSuper;
      capAddr <= violAddr;
    end
  end

  assign padAddr = PAD_W'(capAddr);

  // Slice the captured address into bytes; byte 0 is least significant
  genvar g;
  generate
    for (g = 0; g < ADDR_BYTES; g++) begin : gSlice
      assign addrByte[g] = padAddr[g*DATA_W +: DATA_W];
    end
  endgenerate

  always_comb begin
    statusByte          = '0;
    statusByte[AEF_BIT] = errFlag;
    statusByte[WPF_BIT] = wpfQ;
    statusByte[NXF_BIT] = nxfQ;
    statusByte[SVF_BIT] = svfQ;
  end

  // Offset 0 is status; offsets 1.. return the address, most significant first
  always_comb begin
    regRdData = '0;
    if (regAddr == '0) regRdData = statusByte;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (regAddr == REG_AW'(i + 1)) regRdData = addrByte[ADDR_BYTES-1-i];
    end
  end

endmodule

// File: rtl/violation_status_capture.sv
module violation_status_capture
  import avsc_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int REG_AW = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              violValid,
  input  logic              violWrProt,
  input  logic              violNoExec,
  input  logic              violSuper,
  input  logic [ADDR_W-1:0] violAddr,
  input  logic              cpuSupervisor,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              errIrq,
  output logic              regAccessOverride
);

  ctrlStrobes_t strobes;
  logic         errFlag;

  avsc_ctrl #(.REG_AW(REG_AW), .DATA_W(DATA_W), .STATUS_OFFSET(0)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .violValid (violValid),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobes   (strobes),
    .errFlag   (errFlag),
    .errIrq    (errIrq)
  );

  avsc_datapath #(.ADDR_W(ADDR_W), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .errFlag    (errFlag),
    .violWrProt (violWrProt),
    .violNoExec (violNoExec),
    .violSuper  (violSuper),
    .violAddr   (violAddr),
    .regAddr    (regAddr),
    .regRdData  (regRdData)
  );

  assign regAccessOverride = errFlag && cpuSupervisor;

endmodule

// File: rtl/avsc_checker.sv
module avsc_checker #(
  parameter int REG_AW = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              violValid,
  input logic              cpuSupervisor,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              errIrq,
  input logic              regAccessOverride,
  input logic              errFlag
);

  logic clearHit;
  assign clearHit = regWrEn && (regAddr == '0) && regWrData[7];

  a_r2_flag_sets: assert property (@(posedge clk) disable iff (!rstN)
    violValid |=> errFlag);

  a_r5_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && clearHit && !violValid) |=> !errFlag);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clearHit) |=> errFlag);

  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    violValid |=> errIrq);

  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !violValid |=> !errIrq);

  a_r8_override: assert property (@(posedge clk) disable iff (!rstN)
    regAccessOverride == (errFlag && cpuSupervisor));

  a_r4_zero_bits: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == '0) |-> (regRdData[4:1] == 4'b0000));

  a_r6_status_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clearHit && regAddr == '0) |=> (regAddr != '0) || $stable(regRdData));

endmodule

bind violation_status_capture avsc_checker #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_chk (
  .clk               (clk),
  .rstN              (rstN),
  .violValid         (violValid),
  .cpuSupervisor     (cpuSupervisor),
  .regWrEn           (regWrEn),
  .regAddr           (regAddr),
  .regWrData         (regWrData),
  .regRdData         (regRdData),
  .errIrq            (errIrq),
  .regAccessOverride (regAccessOverride),
  .errFlag           (errFlag)
);

// File: tb/violation_status_capture_tb.sv
module violation_status_capture_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 23;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          violValid = 0, violWrProt = 0, violNoExec = 0, violSuper = 0;
  logic [AW-1:0] violAddr = '0;
  logic          cpuSupervisor = 0, regWrEn = 0;
  logic [1:0]    regAddr = '0;
  logic [7:0]    regWrData = '0;
  logic [7:0]    regRdData;
  logic          errIrq, regAccessOverride;

  int checks = 0, fails = 0;
  bit finished = 0;

  // Reference model state
  bit          mFlag, mWp, mNx, mSv, mIrq;
  bit [AW-1:0] mAddr;

  violation_status_capture u_dut (
    .clk(clk), .rstN(rstN), .violValid(violValid), .violWrProt(violWrProt),
    .violNoExec(violNoExec), .violSuper(violSuper), .violAddr(violAddr),
    .cpuSupervisor(cpuSupervisor), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .errIrq(errIrq),
    .regAccessOverride(regAccessOverride)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0:    return {mFlag, mWp, mNx, 4'b0000, mSv};
      2'd1:    return {1'b0, mAddr[22:16]};
      2'd2:    return mAddr[15:8];
      default: return mAddr[7:0];
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    bit clr;
    clr = regWrEn && regAddr == 2'd0 && regWrData[7];
    if (violValid && (!mFlag || clr)) begin
      mWp = violWrProt; mNx = violNoExec; mSv = violSuper; mAddr = violAddr;
    end
    if (violValid) mFlag = 1;
    else if (clr)  mFlag = 0;
    mIrq = violValid;
  endtask

  // Apply inputs at a falling edge, compare, advance one cycle, compare irq
  task automatic cycle(input bit v, input bit wp, input bit nx, input bit sv,
                       input logic [AW-1:0] a, input bit cs, input bit we,
                       input logic [1:0] ra, input logic [7:0] wd, input string tag);
    violValid = v; violWrProt = wp; violNoExec = nx; violSuper = sv; violAddr = a;
    cpuSupervisor = cs; regWrEn = we; regAddr = ra; regWrData = wd;
    #1;
    check(tag, regRdData, expRead(ra));
    check("R8 override", regAccessOverride, mFlag && cs);
    modelStep();
    @(negedge clk);
    check("R7 irq", errIrq, mIrq);
  endtask

  task automatic readAll(input string tag);
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, '0, 0, 0, 2'(i), 8'h00, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    mFlag = 0; mWp = 0; mNx = 0; mSv = 0; mIrq = 0; mAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values on every offset
    readAll("R1 reset");
    check("R1 irq", errIrq, 0);

    // R2/R3: supervisor write-protect violation, then read back
    cycle(1, 1, 0, 1, 23'h5A_BC_DE, 0, 0, 2'd0, 0, "R2 pre");
    cycle(0, 0, 0, 0, '0, 0, 0, 2'd0, 0, "R2 status");
    check("R2 status value", regRdData, 8'hC1);
    readAll("R3 address");
    check("R3 offset3", expRead(2'd3), 8'hDE);

    // R4 implicit in status compares; R8 override with supervisor
    cycle(0, 0, 0, 0, '0, 1, 0, 2'd0, 0, "R4 zero bits");

    // R6: further violation while flag set is ignored
    cycle(1, 0, 1, 0, 23'h01_02_03, 1, 0, 2'd0, 0, "R6 pre");
    readAll("R6 frozen");

    // R10: writes to address offsets ignored
    cycle(0, 0, 0, 0, '0, 0, 1, 2'd1, 8'hFF, "R10 write1");
    cycle(0, 0, 0, 0, '0, 0, 1, 2'd3, 8'h00, "R10 write3");
    readAll("R10 readback");

    // R5: write 0 has no effect, write 1 clears, captured data kept
    cycle(0, 0, 0, 0, '0, 0, 1, 2'd0, 8'h7F, "R5 write0");
    cycle(0, 0, 0, 0, '0, 0, 1, 2'd0, 8'h80, "R5 write1");
    readAll("R5 after clear");
    check("R5 status after clear", expRead(2'd0), 8'h41);

    // R9: violation and clear together, violation wins
    cycle(1, 0, 0, 0, 23'h11_22_33, 0, 0, 2'd0, 0, "R9 set");
    cycle(1, 0, 1, 1, 23'h7F_FF_00, 0, 1, 2'd0, 8'h80, "R9 collide");
    readAll("R9 new capture");
    check("R9 status model", expRead(2'd0), 8'hA1);

    // Random traffic; cause drawn from three exclusive values
    for (int n = 0; n < 3000; n++) begin
      int cause;
      bit v, we;
      cause = $urandom_range(2);
      v  = ($urandom_range(7) == 0);
      we = ($urandom_range(5) == 0);
      cycle(v, cause == 1, cause == 2, 1'($urandom), AW'($urandom),
            1'($urandom), we, 2'($urandom), 8'($urandom),
            "R2 R3 R5 R6 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule